// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. It counts clock cycles only while two separate enable bits are both set, one in each of two control registers. When the count reaches 2^N, it sets an expiry flag and raises an interrupt. If the count reaches 2^N again while that flag is still set, it sets a reset-status bit and drives a system reset pulse. Software keeps the system alive by writing ones to the status bits. That write clears them and restarts the interval.

A third register holds a free-running timebase counter. Software can read it twice to confirm that the clock is running. A build option makes the enables sticky once the watchdog has started. After that, writes that try to clear either enable are ignored.

Top module: `dual_expiry_wdog`

## Requirements
- R1: Register map, using byte addresses. Offset 0x0 holds bit 3 (reset status), bit 2 (expiry flag) and bit 1 (enable A). Offset 0x4 holds bit 0 (enable B). Offset 0x8 holds the timebase. Unused bits and unmapped addresses read as zero. Read data appears on the clock edge that samples the read strobe.
- R2: The timebase starts at zero when reset is released and advances by one on every clock. Two reads taken two cycles apart differ by 2.
- R3: The interval counter runs only when enable A and enable B are both 1. With only one of them set, no expiry ever occurs.
- R4: The first expiry occurs 2^N clock edges after the edge that starts the run or restarts the interval. It sets the expiry flag, and the interrupt output is a level that follows this flag.
- R5: An expiry while the flag is already set does three things. It sets the reset-status bit. It drives the reset output high for RST_PULSE_LEN cycles, starting on that edge. It leaves the reset-status bit set after the pulse ends.
- R6: Writing offset 0x0 with bit 2 set clears the expiry flag. Writing it with bit 3 set clears the reset status. Either write restarts the interval. Writing 0 to those bits changes neither status bit.
- R7: Keepalive writes issued well inside each interval keep the interrupt and the reset output low indefinitely.
- R8: Clearing either enable stops the counter and holds it at zero. A keepalive write made while the watchdog is disabled still clears the status bits. A later enable then runs a full 2^N interval.
- R9: With ENABLE_ONCE set, both enables ignore writes of 0 once both have been 1. Before that point, both enables are freely writable.
- R10: During reset and directly after it, all registers are zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_irq | output | 1 | Interrupt, high while the expiry flag is set |
| wdt_rst | output | 1 | System reset pulse |

## Verification
Each result has a fixed due edge, counted from the edge that captures the write which starts the run or the keepalive. The interrupt is due exactly 2^N edges later. The reset output is due exactly 2^(N+1) edges later and stays high for RST_PULSE_LEN edges. Read data is due on the edge that samples the strobe. The bench drives and samples on the falling clock. It checks each output on the last edge before its due time and on the due edge itself, so an early or late result by even one cycle is caught. Timebase, lock and disable behaviour are checked through register readback on that same one-edge read latency.

// File: rtl/dew_pkg.sv
package dew_pkg;

    localparam int unsigned BUS_W = 32;

    // bit positions inside the two control words
    localparam int unsigned BIT_RSTST = 3;
    localparam int unsigned BIT_FLAG  = 2;
    localparam int unsigned BIT_ENA   = 1;
    localparam int unsigned BIT_ENB   = 0;

    typedef enum logic [1:0] {
        REG_CTRL_A = 2'd0,
        REG_CTRL_B = 2'd1,
        REG_TBASE  = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic clr_flag;
        logic clr_rst;
    } dew_ctrl_s;

    typedef struct packed {
        logic flag;
        logic rst_stat;
    } dew_status_s;

    function automatic reg_sel_e map_addr(input logic [31:0] a);
        reg_sel_e s;
        s = REG_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[31:2])
                30'd0:   s = REG_CTRL_A;
                30'd1:   s = REG_CTRL_B;
                30'd2:   s = REG_TBASE;
                default: s = REG_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/dew_timebase.sv
module dew_timebase #(
    parameter int unsigned TB_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TB_W-1:0] tb_o
);

    logic [TB_W-1:0] tb_q;

    always_ff @(posedge clk) begin
        if (rst) tb_q <= '0;
        else     tb_q <= tb_q + 1'b1;
    end

    assign tb_o = tb_q;

    AST_TB_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tb_q == $past(tb_q) + 1'b1)); // R2

endmodule

// File: rtl/dew_expiry.sv
module dew_expiry
    import dew_pkg::*;
#(
    parameter int unsigned INTERVAL_LOG2 = 8,
    parameter int unsigned PULSE_LEN     = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  dew_ctrl_s   ctrl_i,
    output dew_status_s status_o,
    output logic        rst_pulse_o
);

    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    logic [INTERVAL_LOG2-1:0] cnt_q;
    logic [PW-1:0]            pulse_q;
    logic                     flag_q;
    logic                     rst_stat_q;
    logic                     kick;
    logic                     expire;

    assign kick   = ctrl_i.clr_flag | ctrl_i.clr_rst;
    assign expire = ctrl_i.run && !kick && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst || !ctrl_i.run || kick) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q     <= 1'b0;
            rst_stat_q <= 1'b0;
        end else begin
            if (ctrl_i.clr_flag) flag_q <= 1'b0;
            else if (expire)     flag_q <= 1'b1;
            if (ctrl_i.clr_rst)         rst_stat_q <= 1'b0;
            else if (expire && flag_q)  rst_stat_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   pulse_q <= '0;
        else if (expire && flag_q) pulse_q <= PW'(PULSE_LEN);
        else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
    end

    assign status_o.flag     = flag_q;
    assign status_o.rst_stat = rst_stat_q;
    assign rst_pulse_o       = (pulse_q != '0);

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.run |=> (cnt_q == '0)); // R8
    AST_NO_IDLE_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.run |=> !$rose(flag_q)); // R3
    AST_FLAG_STAYS: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ctrl_i.clr_flag) |=> flag_q); // R4
    AST_RST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_pulse_o) |-> $past(flag_q)); // R5
    AST_RST_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_pulse_o) |-> rst_stat_q); // R5

endmodule

// File: rtl/dew_regs.sv
module dew_regs
    import dew_pkg::*;
#(
    parameter bit          ENABLE_ONCE = 1'b0,
    parameter int unsigned TB_W        = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             rd_i,
    input  reg_sel_e         sel_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  dew_status_s      status_i,
    input  logic [TB_W-1:0]  tbase_i,
    output dew_ctrl_s        ctrl_o,
    output logic [BUS_W-1:0] rdata_o
);

    logic             ena_q;
    logic             enb_q;
    logic             wr_a;
    logic             wr_b;
    logic             sticky;
    logic [BUS_W-1:0] rdata_d;
    logic [BUS_W-1:0] rdata_q;
    logic             unused_wdata;

    assign wr_a   = wr_i && (sel_i == REG_CTRL_A);
    assign wr_b   = wr_i && (sel_i == REG_CTRL_B);
    assign sticky = ENABLE_ONCE && ena_q && enb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= 1'b0;
            enb_q <= 1'b0;
        end else begin
            if (wr_a && (!sticky || wdata_i[BIT_ENA])) ena_q <= wdata_i[BIT_ENA];
            if (wr_b && (!sticky || wdata_i[BIT_ENB])) enb_q <= wdata_i[BIT_ENB];
        end
    end

    assign ctrl_o.run      = ena_q && enb_q;
    assign ctrl_o.clr_flag = wr_a && wdata_i[BIT_FLAG];
    assign ctrl_o.clr_rst  = wr_a && wdata_i[BIT_RSTST];

    always_comb begin
        rdata_d = '0;
        case (sel_i)
            REG_CTRL_A: begin
                rdata_d[BIT_RSTST] = status_i.rst_stat;
                rdata_d[BIT_FLAG]  = status_i.flag;
                rdata_d[BIT_ENA]   = ena_q;
            end
            REG_CTRL_B: rdata_d[BIT_ENB] = enb_q;
            REG_TBASE:  rdata_d = BUS_W'(tbase_i);
            default:    rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_i) rdata_q <= '0;
        else              rdata_q <= rdata_d;
    end

    assign rdata_o      = rdata_q;
    assign unused_wdata = ^wdata_i[BUS_W-1:4];

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ENABLE_ONCE && ena_q && enb_q) |=> (ena_q && enb_q)); // R9
    AST_CTRLB_READ: assert property (@(posedge clk) disable iff (rst)
        $past(rd_i && sel_i == REG_CTRL_B) |-> (rdata_o[BUS_W-1:1] == '0)); // R1

endmodule

// File: rtl/dual_expiry_wdog.sv
module dual_expiry_wdog
    import dew_pkg::*;
#(
    parameter int unsigned INTERVAL_LOG2 = 8,
    parameter int unsigned RST_PULSE_LEN = 4,
    parameter bit          ENABLE_ONCE   = 1'b0,
    parameter int unsigned TB_W          = 32,
    parameter int unsigned ADDR_W        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst
);

    reg_sel_e        sel;
    dew_ctrl_s       ctrl;
    dew_status_s     status;
    logic [TB_W-1:0] tbase;

    assign sel = map_addr(32'(bus_addr));

    dew_timebase #(.TB_W(TB_W)) u_tbase (
        .clk  (clk),
        .rst  (rst),
        .tb_o (tbase)
    );

    dew_regs #(.ENABLE_ONCE(ENABLE_ONCE), .TB_W(TB_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (bus_we),
        .rd_i     (bus_re),
        .sel_i    (sel),
        .wdata_i  (bus_wdata),
        .status_i (status),
        .tbase_i  (tbase),
        .ctrl_o   (ctrl),
        .rdata_o  (bus_rdata)
    );

    dew_expiry #(.INTERVAL_LOG2(INTERVAL_LOG2), .PULSE_LEN(RST_PULSE_LEN)) u_expiry (
        .clk         (clk),
        .rst         (rst),
        .ctrl_i      (ctrl),
        .status_o    (status),
        .rst_pulse_o (wdt_rst)
    );

    assign wdt_irq = status.flag;

endmodule

// File: tb/test_dual_expiry_wdog.sv
module test_dual_expiry_wdog;

    localparam int CLK_PERIOD = 10;
    localparam int IVL        = 256;   // 2^INTERVAL_LOG2 at default
    localparam int PLEN       = 4;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // register-map walk with the watchdog never running (R1)
    localparam vec_t VECS [0:11] = '{
        '{1'b0, 4'h0, 32'h0,        32'h0},
        '{1'b0, 4'h4, 32'h0,        32'h0},
        '{1'b1, 4'h0, 32'hFFFFFFFF, 32'h0},
        '{1'b0, 4'h0, 32'h0,        32'h2},
        '{1'b0, 4'h4, 32'h0,        32'h0},
        '{1'b1, 4'h0, 32'h0,        32'h0},
        '{1'b0, 4'h0, 32'h0,        32'h0},
        '{1'b1, 4'h4, 32'hFFFFFFFF, 32'h0},
        '{1'b0, 4'h4, 32'h0,        32'h1},
        '{1'b0, 4'hC, 32'h0,        32'h0},
        '{1'b1, 4'h4, 32'h0,        32'h0},
        '{1'b0, 4'h4, 32'h0,        32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  b_addr = '0;
    logic        b_we = 1'b0;
    logic        b_re = 1'b0;
    logic [31:0] b_wdata = '0;
    logic        tsel = 1'b0;
    logic [31:0] rdata_a, rdata_b, rdata;
    logic        irq_a, irq_b, rst_a, rst_b;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_expiry_wdog i_dual_expiry_wdog (
        .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_we(b_we && !tsel),
        .bus_re(b_re && !tsel), .bus_wdata(b_wdata), .bus_rdata(rdata_a),
        .wdt_irq(irq_a), .wdt_rst(rst_a)
    );

    dual_expiry_wdog #(.INTERVAL_LOG2(4), .RST_PULSE_LEN(2), .ENABLE_ONCE(1'b1))
    i_dual_expiry_wdog_lock (
        .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_we(b_we && tsel),
        .bus_re(b_re && tsel), .bus_wdata(b_wdata), .bus_rdata(rdata_b),
        .wdt_irq(irq_b), .wdt_rst(rst_b)
    );

    assign rdata = tsel ? rdata_b : rdata_a;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        b_addr = a; b_wdata = d; b_we = 1'b1;
        @(negedge clk);
        b_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        b_addr = a; b_re = 1'b1;
        @(negedge clk);
        b_re = 1'b0;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        wait_cyc(4);
        chk("R10 irq in reset", 32'(irq_a), 0);
        chk("R10 rst in reset", 32'(rst_a), 0);
        chk("R10 rdata in reset", rdata_a, 0);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr, v);
                chk($sformatf("R1 vector %0d", i), v, VECS[i].exp);
            end
        end
        chk("R10 irq after reset", 32'(irq_a), 0);

        // R2 timebase
        rd(4'h8, v); rd(4'h8, v2);
        chk("R2 timebase step", v2 - v, 2);

        // R3 single enables never expire
        wr(4'h0, 32'h2); wait_cyc(300);
        chk("R3 enable A only", 32'(irq_a), 0);
        wr(4'h0, 32'h0); wr(4'h4, 32'h1); wait_cyc(300);
        chk("R3 enable B only", 32'(irq_a), 0);
        wr(4'h4, 32'h0);

        // R4/R5 two-stage expiry timing
        wr(4'h0, 32'hE); wr(4'h4, 32'h1);
        wait_cyc(IVL - 1);  chk("R4 irq before due", 32'(irq_a), 0);
        wait_cyc(1);        chk("R4 irq at due", 32'(irq_a), 1);
        wait_cyc(IVL - 1);  chk("R5 rst before due", 32'(rst_a), 0);
        wait_cyc(1);        chk("R5 rst at due", 32'(rst_a), 1);
        wait_cyc(PLEN - 1); chk("R5 rst last pulse cycle", 32'(rst_a), 1);
        wait_cyc(1);        chk("R5 rst after pulse", 32'(rst_a), 0);
        rd(4'h0, v);        chk("R5 status stays set", v, 32'hE);

        // R6 keepalive clears and restarts
        wr(4'h0, 32'hE);
        chk("R6 irq cleared", 32'(irq_a), 0);
        wait_cyc(IVL - 1);  chk("R6 restart irq before due", 32'(irq_a), 0);
        wait_cyc(1);        chk("R6 restart irq at due", 32'(irq_a), 1);
        rd(4'h0, v);        chk("R6 flag only", v, 32'h6);
        wr(4'h0, 32'h2);
        rd(4'h0, v);        chk("R6 zero bits keep flag", v, 32'h6);
        wr(4'h0, 32'hA);
        rd(4'h0, v);        chk("R6 bit3 leaves flag", v, 32'h6);

        // R7 regular keepalive
        for (int k = 0; k < 3; k++) begin
            wr(4'h0, 32'h6);
            wait_cyc(200);
            chk("R7 irq stays low", 32'(irq_a), 0);
            chk("R7 rst stays low", 32'(rst_a), 0);
        end

        // R8 disable, clear while disabled, full interval on re-enable
        wait_cyc(IVL);
        chk("R8 irq before disable", 32'(irq_a), 1);
        wr(4'h4, 32'h0); wait_cyc(600);
        chk("R8 no reset while disabled", 32'(rst_a), 0);
        rd(4'h0, v);     chk("R8 flag kept while disabled", v, 32'h6);
        wr(4'h0, 32'hC);
        rd(4'h0, v);     chk("R8 clear while disabled", v, 32'h0);
        wr(4'h0, 32'h2); wr(4'h4, 32'h1);
        wait_cyc(IVL - 1); chk("R8 full interval before due", 32'(irq_a), 0);
        wait_cyc(1);       chk("R8 full interval at due", 32'(irq_a), 1);
        wr(4'h0, 32'hC); wr(4'h4, 32'h0);

        // R9 enable-once instance
        tsel = 1'b1;
        wr(4'h0, 32'h2); wr(4'h0, 32'h0);
        rd(4'h0, v);     chk("R9 writable before run", v, 32'h0);
        wr(4'h0, 32'h2); wr(4'h4, 32'h1);
        wr(4'h0, 32'h0); wr(4'h4, 32'h0);
        rd(4'h0, v);     chk("R9 enable A kept", v & 32'h2, 32'h2);
        rd(4'h4, v);     chk("R9 enable B kept", v, 32'h1);
        wait_cyc(20);
        chk("R9 still running", 32'(irq_b), 1);
        tsel = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule